// File: doc/BRIEF.md
# Serial Flash Page Program Sequencer

This block sits on the host side of an SPI serial flash. It programs one page of the flash and needs no help from software while it runs. A single start request supplies a 24-bit target address and a byte count. The sequencer then runs four kinds of bus frame in a fixed order:

1. A one-byte write-enable frame.
2. A program frame. It carries the program opcode, the address and the payload bytes, which are pulled from a valid/ready byte stream.
3. A chip-enable release, which lets the flash start its internal program cycle.
4. A series of status-read frames, repeated until the flash reports it is no longer busy.

When the status shows the flash is idle, the block raises a one-cycle completion pulse and accepts the next request. The bus runs in SPI mode 0. SCK idles low. Data goes out most significant bit first and is valid on the rising edge. The data returned by the flash is captured on the rising edge. SCK runs at the system clock divided by twice `HALF_DIV`.

A request whose byte count is zero or larger than `MAX_BYTES` gets a one-cycle error pulse and causes no bus activity. While a sequence is in flight, the block holds its payload stream stalled between bytes if the source has no data. In that state SCK is parked low and chip enable stays asserted.

Top module: `flash_page_writer`

## Requirements
- R1: During reset and right after it, the outputs are: chip enable high (deasserted), SCK low, ready-for-start high, completion low, error low, payload ready low.
- R2: A start request taken while ready-for-start is high, with a count of 0 or a count above MAX_BYTES (256), raises error for exactly one cycle, starting on the edge that samples the request. No frame is issued and ready-for-start stays high.
- R3: An accepted request first issues a frame holding exactly one byte, 06h (write enable).
- R4: The second frame is 02h, then the address as three bytes from bits 23:16 down to bits 7:0, then exactly the requested number of payload bytes in handshake order. Payload ready is high only while chip enable is low inside that frame.
- R5: After the program frame, the block issues two-byte frames of 05h followed by a dummy byte. Bit 0 of the second received byte is busy and bits 7:1 are ignored. It repeats these frames until bit 0 reads 0, so a flash that reports busy N times gives N+1 status frames.
- R6: Completion is a single-cycle pulse that follows the last status frame. Ready-for-start is low from the cycle after acceptance through the completion cycle, and is high again on the next cycle.
- R7: SPI mode 0 timing holds. SCK is low whenever chip enable is high. Serial out does not change while SCK is high. Every byte is shifted out most significant bit first.
- R8: Chip enable stays high for at least 2*HALF_DIV system clock cycles between any two frames.
- R9: A start request while ready-for-start is low is ignored. It raises no error and does not disturb the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, sampled when ready-for-start is high |
| addr_i | input | ADDR_W | Target flash address |
| count_i | input | CNT_W | Payload byte count (legal 1..MAX_BYTES) |
| wdat_i | input | 8 | Payload byte |
| wvalid_i | input | 1 | Payload byte valid |
| wready_o | output | 1 | Payload byte taken when high together with valid |
| idle_o | output | 1 | Ready for a new start request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for an illegal byte count |
| sck_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Active-low chip enable |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
Two things can land in the same system clock cycle. One is the shift engine signalling that a byte has finished. The other is the next payload byte being offered on the stream, so the hand-over between the two is the timing-sensitive point. The bench provokes this by letting the valid gap before each payload byte vary randomly from zero to several cycles: some bytes arrive exactly as the previous one finishes, and others arrive after SCK has been parked. It judges the result by rebuilding every program frame from the bus at the flash side and comparing each payload byte against what the bench sent. It also checks the frame's exact length and that no frame ends on a partial byte.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_PROG,
    ST_DATA,
    ST_POLL,
    ST_GAP,
    ST_END
  } fpw_state_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;

  function automatic logic in_frame(input fpw_state_t s);
    return (s == ST_WREN) || (s == ST_PROG) || (s == ST_DATA) || (s == ST_POLL);
  endfunction

endpackage

// File: rtl/fpw_tick.sv
module fpw_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  generate
    if (HALF_DIV <= 1) begin : g_full
      assign tick_o = en_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!en_i) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_o = en_i && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/fpw_shift.sv
module fpw_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o
);

  logic       act_q, act_d;
  logic       sck_q, sck_d;
  logic [7:0] sr_q, sr_d;
  logic [7:0] rx_q, rx_d;
  logic [2:0] bit_q, bit_d;
  logic       fin;

  always_comb begin
    act_d = act_q;
    sck_d = sck_q;
    sr_d  = sr_q;
    rx_d  = rx_q;
    bit_d = bit_q;
    fin   = 1'b0;
    if (!act_q) begin
      if (load_i) begin
        act_d = 1'b1;
        sr_d  = byte_i;
        bit_d = '0;
      end
    end else if (tick_i) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso_i};
      end else begin
        sck_d = 1'b0;
        sr_d  = {sr_q[6:0], 1'b0};
        bit_d = bit_q + 1'b1;
        if (bit_q == 3'd7) begin
          act_d = 1'b0;
          fin   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      sr_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      act_q <= act_d;
      sck_q <= sck_d;
      sr_q  <= sr_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
    end
  end

  assign busy_o = act_q;
  assign done_o = fin;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = sr_q[7];

endmodule

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_BYTES = 256,
  parameter int HALF_DIV  = 2,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [7:0]        wdat_i,
  input  logic              wvalid_i,
  input  logic              sh_busy_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              sh_load_o,
  output logic [7:0]        sh_byte_o,
  output logic              wready_o,
  output logic              idle_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_n_o
);

  localparam int AB      = ADDR_W / 8;
  localparam int GAP_LEN = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_LEN + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(AB);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BYTES);
  localparam logic [GW-1:0]    GAP_END  = GW'(GAP_LEN - 1);

  fpw_state_t        st_q, st_d, nxt_q, nxt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              iss_q, iss_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              err_q, err_d;
  logic [7:0]        hdr;
  logic              free;

  // byte of the program header selected by the byte index
  always_comb begin
    hdr = OP_PROG;
    for (int k = 1; k <= AB; k++) begin
      if (idx_q == CNT_W'(k)) begin
        hdr = addr_q[(AB-k)*8 +: 8];
      end
    end
  end

  assign free = !iss_q && !sh_busy_i;

  always_comb begin
    st_d      = st_q;
    nxt_d     = nxt_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    iss_d     = iss_q;
    gap_d     = gap_q;
    err_d     = 1'b0;
    sh_load_o = 1'b0;
    sh_byte_o = OP_DUMMY;
    wready_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if ((count_i == '0) || (count_i > CNT_MAX)) begin
            err_d = 1'b1;
          end else begin
            addr_d = addr_i;
            cnt_d  = count_i;
            idx_d  = '0;
            iss_d  = 1'b0;
            st_d   = ST_WREN;
          end
        end
      end
      ST_WREN: begin
        sh_byte_o = OP_WREN;
        if (free) begin
          sh_load_o = 1'b1;
          iss_d     = 1'b1;
        end
        if (sh_done_i) begin
          iss_d = 1'b0;
          gap_d = '0;
          nxt_d = ST_PROG;
          st_d  = ST_GAP;
        end
      end
      ST_PROG: begin
        sh_byte_o = hdr;
        if (free) begin
          sh_load_o = 1'b1;
          iss_d     = 1'b1;
        end
        if (sh_done_i) begin
          iss_d = 1'b0;
          if (idx_q == HDR_LAST) begin
            idx_d = '0;
            st_d  = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        sh_byte_o = wdat_i;
        wready_o  = free;
        if (free && wvalid_i) begin
          sh_load_o = 1'b1;
          iss_d     = 1'b1;
        end
        if (sh_done_i) begin
          iss_d = 1'b0;
          if (idx_q == cnt_q - 1'b1) begin
            idx_d = '0;
            gap_d = '0;
            nxt_d = ST_POLL;
            st_d  = ST_GAP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_POLL: begin
        sh_byte_o = (idx_q == '0) ? OP_STAT : OP_DUMMY;
        if (free) begin
          sh_load_o = 1'b1;
          iss_d     = 1'b1;
        end
        if (sh_done_i) begin
          iss_d = 1'b0;
          if (idx_q == '0) begin
            idx_d = CNT_W'(1);
          end else begin
            idx_d = '0;
            gap_d = '0;
            nxt_d = sh_rx_i[0] ? ST_POLL : ST_END;
            st_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_END) begin
          st_d = nxt_q;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_END: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      iss_q  <= 1'b0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      nxt_q  <= nxt_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      iss_q  <= iss_d;
      gap_q  <= gap_d;
      err_q  <= err_d;
    end
  end

  assign idle_o = (st_q == ST_IDLE);
  assign done_o = (st_q == ST_END);
  assign err_o  = err_q;
  assign cs_n_o = !in_frame(st_q);

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int ADDR_W    = 24,
  parameter int MAX_BYTES = 256,
  parameter int HALF_DIV  = 2,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [7:0]        wdat_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              idle_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       sh_load, sh_busy, sh_done, tick;
  logic [7:0] sh_byte, sh_rx;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  fpw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sn),
    .en_i   (sh_busy),
    .tick_o (tick)
  );

  fpw_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_sn),
    .load_i (sh_load),
    .byte_i (sh_byte),
    .tick_i (tick),
    .miso_i (miso_i),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  fpw_ctrl #(
    .ADDR_W    (ADDR_W),
    .MAX_BYTES (MAX_BYTES),
    .HALF_DIV  (HALF_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .count_i   (count_i),
    .wdat_i    (wdat_i),
    .wvalid_i  (wvalid_i),
    .sh_busy_i (sh_busy),
    .sh_done_i (sh_done),
    .sh_rx_i   (sh_rx),
    .sh_load_o (sh_load),
    .sh_byte_o (sh_byte),
    .wready_o  (wready_o),
    .idle_o    (idle_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .cs_n_o    (cs_n_o)
  );

endmodule

// File: rtl/fpw_sva.sv
module fpw_sva #(
  parameter int MAX_BYTES = 256,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             wready_o,
  input logic             idle_o,
  input logic             done_o,
  input logic             err_o,
  input logic             sck_o,
  input logic             cs_n_o,
  input logic             mosi_o
);

  p_bad_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i && ((count_i == '0) || (count_i > CNT_W'(MAX_BYTES)))) |=> err_o);

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cs_n_o && idle_o));

  p_ready_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wready_o |-> (!cs_n_o && !idle_o));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && idle_o));

  p_sck_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && start_i) |=> !err_o);

endmodule

bind flash_page_writer fpw_sva #(.MAX_BYTES(MAX_BYTES)) u_sva (
  .clk      (clk),
  .rst_n    (rst_sn),
  .start_i  (start_i),
  .count_i  (count_i),
  .wready_o (wready_o),
  .idle_o   (idle_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .sck_o    (sck_o),
  .cs_n_o   (cs_n_o),
  .mosi_o   (mosi_o)
);

// File: tb/flash_page_writer_test.sv
module flash_page_writer_test;

  localparam int HALF = 2;
  localparam int MAXB = 256;
  localparam int NFR  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [8:0]  count_i = '0;
  logic [7:0]  wdat_i = '0;
  logic        wvalid_i = 1'b0;
  logic        wready_o, idle_o, done_o, err_o, sck_o, cs_n_o, mosi_o;
  logic        miso = 1'b0;

  always #5 clk = ~clk;

  flash_page_writer #(.ADDR_W(24), .MAX_BYTES(MAXB), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
    .wdat_i(wdat_i), .wvalid_i(wvalid_i), .wready_o(wready_o), .idle_o(idle_o),
    .done_o(done_o), .err_o(err_o), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .mosi_o(mosi_o), .miso_i(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash-side model ----------------
  int         nfr = 0;
  int         nb = 0;
  int         bitc = 0;
  logic [7:0] sh = '0;
  logic [7:0] first = '0;
  int         fr_len [NFR];
  logic [7:0] fr_b   [NFR][4];
  int         fr_bad [NFR];
  logic [7:0] exp_data [MAXB];
  int         busy_left = 0;
  int         plan_polls = 0;

  always @(posedge sck_o or posedge cs_n_o) begin
    if (cs_n_o) begin
      if (nb > 0 || bitc > 0) begin
        if (nfr < NFR) fr_len[nfr] = (bitc != 0) ? -1 : nb;
        if (first == 8'h05 && busy_left > 0) busy_left--;
        if (first == 8'h02) busy_left = plan_polls;
        nfr++;
      end
      nb = 0;
      bitc = 0;
    end else begin
      sh = {sh[6:0], mosi_o};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (nb == 0) begin
          first = sh;
          if (nfr < NFR) fr_bad[nfr] = 0;
        end
        if (nb < 4 && nfr < NFR) fr_b[nfr][nb] = sh;
        if (first == 8'h02 && nb >= 4 && nfr < NFR) begin
          if (nb - 4 >= MAXB) fr_bad[nfr]++;
          else if (sh != exp_data[nb-4]) fr_bad[nfr]++;
        end
        nb++;
      end
    end
  end

  // status byte: bits 7:1 set to a pattern that must be ignored, bit 0 busy
  always @(negedge sck_o or negedge cs_n_o) begin
    if (!cs_n_o && sck_o == 1'b0 && nb == 1 && first == 8'h05) begin
      miso = ({7'h55, (busy_left > 0)} >> (7 - bitc)) & 8'h01;
    end else begin
      miso = 1'b0;
    end
  end

  // ---------------- bus timing monitor (R7, R8) ----------------
  int hi_cnt = 0;
  bit seen_frame = 0;
  bit prev_cs = 1'b1;
  int mon_checks = 0;
  int mon_errors = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n_o) begin
        hi_cnt++;
        if (sck_o) begin
          mon_errors++;
          $display("FAIL R7 sck high while chip enable is high actual=1 expected=0");
        end
      end else if (prev_cs) begin
        mon_checks++;
        if (seen_frame && hi_cnt < 2 * HALF) begin
          mon_errors++;
          $display("FAIL R8 chip enable gap actual=%0d expected=%0d", hi_cnt, 2 * HALF);
        end
        seen_frame = 1;
        hi_cnt = 0;
      end
      prev_cs = cs_n_o;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic run_op(input logic [23:0] a, input int cnt, input int polls, input int gapmax);
    int base;
    int cyc;
    int n;
    for (int i = 0; i < cnt; i++) exp_data[i] = 8'($urandom);
    plan_polls = polls;
    base = nfr;
    @(negedge clk);
    addr_i  = a;
    count_i = 9'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(idle_o == 1'b0, "R6 ready low after accept", idle_o, 0);
    chk(err_o == 1'b0, "R2 no error on legal count", err_o, 0);
    for (int i = 0; i < cnt; i++) begin
      repeat ($urandom % (gapmax + 1)) @(negedge clk);
      wvalid_i = 1'b1;
      wdat_i   = exp_data[i];
      while (!wready_o) @(negedge clk);
      @(negedge clk);
      wvalid_i = 1'b0;
      wdat_i   = 8'($urandom);
    end
    // R9: a request while busy, with a count that would otherwise be illegal
    start_i = 1'b1;
    count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b0 && idle_o == 1'b0, "R9 start ignored while busy", err_o, 0);
    cyc = 0;
    while (!done_o && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, "R6 completion pulse seen", done_o, 1);
    chk(cs_n_o == 1'b1 && idle_o == 1'b0, "R6 ready low during completion", idle_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0 && idle_o == 1'b1, "R6 single pulse then ready", {done_o, idle_o}, 1);
    n = nfr - base;
    chk(n == 3 + polls, "R5 total frame count", n, 3 + polls);
    if (base + 2 + polls < NFR && n == 3 + polls) begin
      chk(fr_len[base] == 1 && fr_b[base][0] == 8'h06, "R3 write-enable frame",
          fr_b[base][0], 8'h06);
      chk(fr_b[base+1][0] == 8'h02, "R4 program opcode", fr_b[base+1][0], 8'h02);
      chk({fr_b[base+1][1], fr_b[base+1][2], fr_b[base+1][3]} == a, "R4 address order",
          {fr_b[base+1][1], fr_b[base+1][2], fr_b[base+1][3]}, a);
      chk(fr_len[base+1] == 4 + cnt, "R4 program frame length", fr_len[base+1], 4 + cnt);
      chk(fr_bad[base+1] == 0, "R4 payload bytes", fr_bad[base+1], 0);
      for (int p = 0; p <= polls; p++) begin
        chk(fr_len[base+2+p] == 2 && fr_b[base+2+p][0] == 8'h05, "R5 status frame",
            fr_b[base+2+p][0], 8'h05);
      end
    end
  endtask

  task automatic bad_count(input int c);
    int base;
    bit touched;
    base = nfr;
    touched = 0;
    @(negedge clk);
    count_i = 9'(c);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R2 error pulse on illegal count", err_o, 1);
    @(negedge clk);
    chk(err_o == 1'b0, "R2 error lasts one cycle", err_o, 0);
    repeat (20) begin
      @(negedge clk);
      if (!cs_n_o || sck_o) touched = 1;
    end
    chk(!touched && nfr == base && idle_o, "R2 no bus activity", nfr - base, 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sck_o && idle_o && !done_o && !err_o && !wready_o,
        "R1 outputs during reset", {cs_n_o, sck_o, idle_o, done_o, err_o, wready_o}, 6'b101000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o && !sck_o && idle_o && !done_o && !err_o && !wready_o,
        "R1 outputs after reset", {cs_n_o, sck_o, idle_o, done_o, err_o, wready_o}, 6'b101000);

    run_op(24'hA5C30F, 1, 0, 0);        // smallest payload, flash idle at once
    run_op(24'h1234FF, MAXB, 2, 0);     // full page, back-to-back bytes
    bad_count(0);
    bad_count(MAXB + 1);
    bad_count(511);
    run_op(24'h000100, 6, 1, 12);       // long stalls with chip enable low
    for (int k = 0; k < 6; k++) begin
      run_op(24'($urandom), 1 + int'($urandom % 40), int'($urandom % 4), int'($urandom % 4));
    end
    run_op(24'hFFFFFF, 255, 3, 1);

    $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + mon_errors + 1, checks + mon_checks + 1);
    $finish;
  end

endmodule